// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds. A free-running prescaler divides the system clock down to a one-cycle enable once per second. Software reaches the block through a 4 KB window on a simple APB-style register bus. Through that window it can preset the count, program a match value and read the live count back. When the count becomes equal to the match value, a sticky raw status flag is set. The flag drives a level interrupt through a one-bit mask, and software clears it by writing a 1 to the clear register.

A write transfer takes effect in the access phase (select and enable both high, write high). Read data is combinational from the address while the access phase lasts. The top 32 bytes of the window hold eight word-spaced, read-only identification bytes.

Top module: `rtc_alarm`

## Requirements
- R1: The data register (offset 0x00) reads the live count. The count increments by one on each prescaler tick, which comes once every TICK_DIV clock cycles, and wraps from 0xFFFFFFFF to 0.
- R2: A write to the load register (offset 0x08) sets the count to the written value. Reading the load register returns the last value written to it.
- R3: The match register (offset 0x04) reads back as written. When a count update makes the count equal to the match value, bit 0 of the raw status register (offset 0x14) is set on the next clock edge.
- R4: If a write to the match or load register leaves the count equal to the match value, raw status sets on the clock edge that completes that write.
- R5: The mask register (offset 0x10) stores only bit 0, and all other bits read 0. Both irq_o and the masked status register (offset 0x18) equal raw status AND mask.
- R6: A write to the clear register (offset 0x1C) with bit 0 set clears raw status. With bit 0 clear, the write has no effect. A match event in the same cycle overrides the clear. The clear register reads 0.
- R7: The control register (offset 0x0C) always reads 1, and writes to it have no effect.
- R8: Writes to the data, raw status and masked status registers are ignored.
- R9: Offsets 0xFE0 to 0xFFF return identification bytes indexed by offset bits [4:2]. Index 0 through 7 give 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Every other offset reads 0. This includes the register offsets 0x00 to 0x1F when the address is not word-aligned.
- R11: After reset, the count, match, load, mask and raw status are all zero, and irq_o is low.
- R12: Raw status is set only on the cycle a match event occurs. After a clear, it stays clear while the count and match value are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write (1) or read (0) |
| paddr_i | input | 12 | Byte address within the 4 KB window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt: raw status AND mask |

## Verification
The bench goes after the immediate-match cases: a match write landing just after a tick, and a load written equal to the match value. A design that only compared on ticks would leave the flag low there. It checks that a clear stays clear while count and match hold still. A level comparison instead of an event would set the flag again at once. The bench also runs the count through the 0xFFFFFFFF wrap to a match at 1. It probes a clear written with bit 0 low, writes to the read-only registers, unaligned addresses and the whole ID range, where a loose decode would corrupt state or return the wrong byte.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] OFF_DATA  = 12'h000;
  localparam logic [AW-1:0] OFF_MATCH = 12'h004;
  localparam logic [AW-1:0] OFF_LOAD  = 12'h008;
  localparam logic [AW-1:0] OFF_CTRL  = 12'h00C;
  localparam logic [AW-1:0] OFF_MASK  = 12'h010;
  localparam logic [AW-1:0] OFF_RAW   = 12'h014;
  localparam logic [AW-1:0] OFF_MSTAT = 12'h018;
  localparam logic [AW-1:0] OFF_CLR   = 12'h01C;
  localparam logic [AW-1:0] OFF_IDBAS = 12'hFE0;

  typedef struct packed {
    logic match_we;
    logic load_we;
    logic mask_we;
    logic clr_we;
  } wr_strb_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  if (TICK_DIV <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_div
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
    assign tick_o = (cnt_q == LAST);

    AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R1
  end
endmodule

// File: rtl/rtc_count_match.sv
module rtc_count_match #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_we_i,
  input  logic          match_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] match_o,
  output logic [DW-1:0] load_o,
  output logic          hit_o
);
  logic [DW-1:0] count_q, match_q, load_q;
  logic [DW-1:0] count_nxt, match_nxt;
  logic          upd;

  // load write beats a coincident tick
  always_comb begin
    count_nxt = load_we_i ? wdata_i : (tick_i ? count_q + 1'b1 : count_q);
    match_nxt = match_we_i ? wdata_i : match_q;
    upd       = tick_i | load_we_i | match_we_i;
    hit_o     = upd & (count_nxt == match_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      match_q <= '0;
      load_q  <= '0;
    end else begin
      count_q <= count_nxt;
      match_q <= match_nxt;
      if (load_we_i) load_q <= wdata_i;
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;
  assign load_o  = load_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_we_i) |=> (count_q == $past(count_q) + 1'b1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_we_i) |=> $stable(count_q)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> (count_q == $past(wdata_i) && load_q == $past(wdata_i))); // R2
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mask_we_i,
  input  logic clr_we_i,
  input  logic wbit_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (hit_i)                    raw_q <= 1'b1;
      else if (clr_we_i && wbit_i)  raw_q <= 1'b0;
      if (mask_we_i)                mask_q <= wbit_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;

  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> raw_q); // R3
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wbit_i && !hit_i) |=> !raw_q); // R6
  AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !(clr_we_i && wbit_i)) |=> $stable(raw_q)); // R12
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |-> !irq_o); // R5
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned DW       = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  output logic          irq_o
);
  logic          wr_en, tick;
  wr_strb_t      strb;
  logic [DW-1:0] count, match, load;
  logic          hit, raw, mask;

  assign wr_en = psel_i & penable_i & pwrite_i;

  always_comb begin
    strb          = '0;
    strb.match_we = wr_en && (paddr_i == OFF_MATCH);
    strb.load_we  = wr_en && (paddr_i == OFF_LOAD);
    strb.mask_we  = wr_en && (paddr_i == OFF_MASK);
    strb.clr_we   = wr_en && (paddr_i == OFF_CLR);
  end

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rtc_count_match #(.DW(DW)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_we_i (strb.load_we),
    .match_we_i(strb.match_we),
    .wdata_i   (pwdata_i),
    .count_o   (count),
    .match_o   (match),
    .load_o    (load),
    .hit_o     (hit)
  );

  rtc_irq_ctl i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .mask_we_i(strb.mask_we),
    .clr_we_i (strb.clr_we),
    .wbit_i   (pwdata_i[0]),
    .raw_o    (raw),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    prdata_o = '0;
    if (paddr_i >= OFF_IDBAS) begin
      prdata_o = DW'(id_byte(paddr_i[4:2]));
    end else begin
      case (paddr_i)
        OFF_DATA:  prdata_o = count;
        OFF_MATCH: prdata_o = match;
        OFF_LOAD:  prdata_o = load;
        OFF_CTRL:  prdata_o = DW'(1);
        OFF_MASK:  prdata_o = DW'(mask);
        OFF_RAW:   prdata_o = DW'(raw);
        OFF_MSTAT: prdata_o = DW'(raw & mask);
        default:   prdata_o = '0;
      endcase
    end
  end

  AST_IRQ_LOW_UNSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw |-> !irq_o); // R5
endmodule

// File: tb/test_rtc_alarm.sv
`timescale 1ns/1ps
module test_rtc_alarm;
  localparam int unsigned DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm #(.TICK_DIV(DIV), .DW(32)) i_rtc_alarm (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq)
  );

  // reference model
  int unsigned m_div;
  bit [31:0]   m_count, m_match, m_load;
  bit          m_mask, m_raw;
  byte unsigned id_tab[8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_count = 0; m_match = 0; m_load = 0; m_mask = 0; m_raw = 0;
    end else begin
      bit tk, up, clr;
      bit [31:0] cn, mn;
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      cn = tk ? m_count + 1 : m_count;
      mn = m_match; up = tk; clr = 0;
      if (psel && penable && pwrite) begin
        case (paddr)
          12'h004: begin mn = pwdata; up = 1; end
          12'h008: begin cn = pwdata; m_load = pwdata; up = 1; end
          12'h010: m_mask = pwdata[0];
          12'h01C: clr = pwdata[0];
          default: ;
        endcase
      end
      if (up && cn == mn) m_raw = 1;
      else if (clr)       m_raw = 0;
      m_count = cn; m_match = mn;
    end
  end

  function automatic bit [31:0] model_read(input bit [11:0] a);
    if (a >= 12'hFE0) return 32'(id_tab[a[4:2]]);
    case (a)
      12'h000: return m_count;
      12'h004: return m_match;
      12'h008: return m_load;
      12'h00C: return 32'd1;
      12'h010: return 32'(m_mask);
      12'h014: return 32'(m_raw);
      12'h018: return 32'(m_raw & m_mask);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input bit [11:0] a);
    if (a >= 12'hFE0) return "R9";
    case (a)
      12'h000: return "R1";
      12'h004: return "R3";
      12'h008: return "R2";
      12'h00C: return "R7";
      12'h010, 12'h018: return "R5";
      12'h014: return "R3";
      12'h01C: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit [31:0] act, input bit [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", req, $time, act, exp);
    end
  endtask

  // per-clock compare
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(32'(irq), 32'(m_raw & m_mask), "R5");
      if (psel && penable && !pwrite) check(prdata, model_read(paddr), req_of(paddr));
    end
  end

  task automatic apb_write(input bit [11:0] a, input bit [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input bit [11:0] a, output bit [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    @(negedge clk); d = prdata;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input bit [11:0] a, input bit [31:0] exp, input string req);
    bit [31:0] d;
    apb_read(a, d);
    check(d, exp, req);
  endtask

  task automatic wait_after_tick;
    do begin @(posedge clk); #1; end while (m_div != 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit [31:0] d;
    repeat (3) @(negedge clk);
    check(32'(irq), 32'd0, "R11");
    @(posedge clk); #1 rst_n = 1;
    rd_chk(12'h004, 32'd0, "R11");
    rd_chk(12'h008, 32'd0, "R11");
    rd_chk(12'h010, 32'd0, "R11");
    rd_chk(12'h014, 32'd0, "R11");
    check(32'(irq), 32'd0, "R11");

    // R1 live count
    repeat (20) @(posedge clk);
    apb_read(12'h000, d);

    // R2 load and readback
    apb_write(12'h008, 32'd100);
    rd_chk(12'h008, 32'd100, "R2");
    apb_read(12'h000, d);

    // R3 future match raises irq
    apb_write(12'h010, 32'd1);
    apb_write(12'h004, m_count + 3);
    repeat (40) @(posedge clk);
    rd_chk(12'h014, 32'd1, "R3");
    rd_chk(12'h018, 32'd1, "R5");
    @(negedge clk) check(32'(irq), 32'd1, "R5");

    // R6 clear, clear reads zero
    apb_write(12'h01C, 32'h1);
    rd_chk(12'h014, 32'd0, "R6");
    rd_chk(12'h01C, 32'd0, "R6");

    // R4 match write equal to count
    wait_after_tick();
    apb_write(12'h004, m_count);
    rd_chk(12'h014, 32'd1, "R4");
    // R12 no re-set after clear with nothing changed
    apb_write(12'h01C, 32'h1);
    rd_chk(12'h014, 32'd0, "R12");
    repeat (5) @(posedge clk);
    rd_chk(12'h014, 32'd0, "R12");

    // R4 load written equal to match
    apb_write(12'h008, m_match);
    rd_chk(12'h014, 32'd1, "R4");

    // R6 clear with bit 0 low has no effect
    apb_write(12'h01C, 32'hFFFF_FFFE);
    rd_chk(12'h014, 32'd1, "R6");

    // R5 mask keeps bit 0 only
    apb_write(12'h010, 32'hFFFF_FFFE);
    rd_chk(12'h010, 32'd0, "R5");
    rd_chk(12'h018, 32'd0, "R5");
    @(negedge clk) check(32'(irq), 32'd0, "R5");
    apb_write(12'h010, 32'h3);
    rd_chk(12'h010, 32'd1, "R5");

    // R7 control
    apb_write(12'h00C, 32'h0);
    rd_chk(12'h00C, 32'd1, "R7");

    // R8 read-only registers ignore writes
    apb_write(12'h000, 32'h5555_5555);
    apb_read(12'h000, d);
    check(32'(d == 32'h5555_5555), 32'd0, "R8");
    apb_write(12'h014, 32'h0);
    rd_chk(12'h014, 32'd1, "R8");
    apb_write(12'h018, 32'h0);
    rd_chk(12'h014, 32'd1, "R8");

    // R9 ID bytes
    for (int i = 0; i < 8; i++) rd_chk(12'hFE0 + 12'(4 * i), 32'(id_tab[i]), "R9");
    rd_chk(12'hFE1, 32'h31, "R9");
    rd_chk(12'hFFF, 32'hB1, "R9");

    // R10 unmapped
    rd_chk(12'h020, 32'd0, "R10");
    rd_chk(12'h800, 32'd0, "R10");
    rd_chk(12'h001, 32'd0, "R10");
    rd_chk(12'h016, 32'd0, "R10");

    // R1 wrap through 0xFFFFFFFF to match at 1
    apb_write(12'h01C, 32'h1);
    apb_write(12'h004, 32'd1);
    apb_write(12'h008, 32'hFFFF_FFFE);
    rd_chk(12'h014, 32'd0, "R1");
    repeat (4 * DIV) @(posedge clk);
    rd_chk(12'h014, 32'd1, "R1");
    apb_read(12'h000, d);
    check(32'(d < 32'd8), 32'd1, "R1");

    repeat (4) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule